// File: doc/BRIEF.md
# Two-Step Flash Code Assembler

This block is the digital back end of a subranging converter that resolves each sample in two flash passes over one comparator array. In the coarse pass it takes the thermometer word of the comparator bank. It produces the upper half of the result, an out-of-range flag and the index of the ladder tap that the residue path must subtract. In the fine pass the same bank digitizes the amplified residue, and the block produces the lower half. Both passes go through one shared ones-count encoder.

The results collect in a first-level holding register. A single-cycle transfer strobe copies all of them at once into the output register. The output is a two's-complement word plus an over-range flag. A host reading the output at any time sees either the previous complete sample or the new complete sample, never a blend of the two. With the default of 5 bits per pass, the comparator word is 33 bits wide and the result is 10 bits wide.

Top module: `flash_code_assembler`

## Requirements
- R1: After reset, `code_o`, `ovr_o` and `tap_o` are all zero.
- R2: On a clock edge with `coarse_i` high, let n be the number of ones in `therm_i`. For n in 1..32, `tap_o` becomes n-1. The upper field (`code_o[9:5]` after transfer) becomes n-1 with its top bit inverted, which gives a two's-complement upper half. Examples: n=17 with fine 0 gives 0x000; n=32 with fine 31 gives 0x1FF; n=1 with fine 0 gives 0x200; n=16 with fine 31 gives 0x3FF.
- R3: On a clock edge with `fine_i` high and `coarse_i` low, the lower field (`code_o[4:0]` after transfer) becomes the ones count minus one, saturated to the range 0..31. A count of 0 gives 0 and a count of 33 gives 31.
- R4: A coarse count of 0 sets `tap_o` to 0 and a coarse count of 33 sets `tap_o` to 31. `tap_o` changes only on a coarse edge.
- R5: `code_o` and `ovr_o` change only on the edge that follows a cycle with `xfer_i` high, and all their bits change on that edge. Coarse and fine writes made before the transfer leave them unchanged.
- R6: A coarse count of 33 (positive over-range) gives `ovr_o`=1 and `code_o`=0x000 after transfer. A coarse count of 0 (negative over-range) gives `ovr_o`=1 and `code_o`=0x200. The fine result has no effect on the output in either case.
- R7: The encoders count ones and do not search for the top edge. A thermometer word with a bubble therefore encodes to the same value as the clean word with the same number of ones.
- R8: When `coarse_i` and `fine_i` are high on the same edge, the coarse write takes place and the fine write is dropped. The lower field keeps its earlier value.
- R9: When `xfer_i` is high on the same edge as a write to the holding register, the output receives the holding contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| therm_i | input | 33 | Comparator thermometer word for the current pass |
| coarse_i | input | 1 | Capture `therm_i` as the coarse pass |
| fine_i | input | 1 | Capture `therm_i` as the fine pass |
| xfer_i | input | 1 | Copy the holding register to the output register |
| tap_o | output | 5 | Selected coarse ladder tap for the residue path |
| code_o | output | 10 | Two's-complement result |
| ovr_o | output | 1 | Over-range flag; the sign is in `code_o[9]` |

## Verification
The bench drives the four named scale points and both over-range directions, and compares each result with its literal code. A design that forgot to invert the top bit of the upper field would turn zero input into 0x200. A design that skipped the forcing would leave magnitude bits set on over-range. The bench also supplies words with an inserted bubble, fine words with zero and full counts, and both strobes in the same cycle. Edge-search encoding, a missing clamp, or the wrong strobe priority each produce a different code in those tests. After every coarse and every fine write, the bench reads the output to confirm that it still holds the previous sample.

// File: rtl/flash_code_assembler.sv
module flash_code_assembler #(
  parameter int SEG_BITS = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [(1<<SEG_BITS):0]  therm_i,
  input  logic                    coarse_i,
  input  logic                    fine_i,
  input  logic                    xfer_i,
  output logic [SEG_BITS-1:0]     tap_o,
  output logic [2*SEG_BITS-1:0]   code_o,
  output logic                    ovr_o
);
  localparam int SEGS  = 1 << SEG_BITS;
  localparam int NCMP  = SEGS + 1;
  localparam int CW    = 2 * SEG_BITS;
  localparam int CNT_W = $clog2(NCMP + 1);
  localparam logic [SEG_BITS-1:0] TOP_BIT = SEG_BITS'(1) << (SEG_BITS - 1);

  logic [CNT_W-1:0]    ones;
  logic                under, over;
  logic [SEG_BITS-1:0] seg;
  logic [SEG_BITS-1:0] up_q, lo_q;
  logic                oor_q, neg_q;

  always_comb begin
    ones = '0;
    for (int i = 0; i < NCMP; i++) ones = ones + CNT_W'(therm_i[i]);
  end

  assign under = (ones == '0);
  assign over  = (ones == CNT_W'(NCMP));
  assign seg   = under ? '0 : over ? SEG_BITS'(SEGS - 1) : SEG_BITS'(ones - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q  <= '0;
      lo_q  <= '0;
      oor_q <= 1'b0;
      neg_q <= 1'b0;
      tap_o <= '0;
    end else if (coarse_i) begin
      up_q  <= seg ^ TOP_BIT;
      tap_o <= seg;
      oor_q <= under | over;
      neg_q <= under;
    end else if (fine_i) begin
      lo_q  <= seg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o <= '0;
      ovr_o  <= 1'b0;
    end else if (xfer_i) begin
      code_o <= oor_q ? {neg_q, {(CW-1){1'b0}}} : {up_q, lo_q};
      ovr_o  <= oor_q;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_i |=> $stable(code_o) && $stable(ovr_o)); // R5

  AST_OVR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |-> code_o[CW-2:0] == '0); // R6

  AST_TAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_i && therm_i == '0 |=> tap_o == '0); // R4

  AST_TAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !coarse_i |=> $stable(tap_o)); // R4

  AST_COARSE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_i && fine_i |=> $stable(lo_q)); // R8

  AST_XFER_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_i && !oor_q |=> code_o[SEG_BITS-1:0] == $past(lo_q)); // R9
endmodule

// File: tb/flash_code_assembler_bench.sv
module flash_code_assembler_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [32:0] therm = '0;
  logic        cv = 1'b0, fv = 1'b0, xv = 1'b0;
  logic [4:0]  tap;
  logic [9:0]  code;
  logic        ovr;
  int checks = 0, errors = 0;

  logic [4:0] m_up = '0, m_lo = '0, m_tap = '0;
  logic       m_oor = 1'b0, m_neg = 1'b0;
  logic [9:0] m_code = '0;
  logic       m_ovr = 1'b0;

  always #2 clk = ~clk;

  flash_code_assembler u_flash_code_assembler (
    .clk(clk), .rst_n(rst_n), .therm_i(therm), .coarse_i(cv), .fine_i(fv),
    .xfer_i(xv), .tap_o(tap), .code_o(code), .ovr_o(ovr));

  function automatic logic [32:0] lvl(int n);
    return (n == 0) ? 33'd0 : 33'((34'd1 << n) - 34'd1);
  endfunction

  function automatic int cnt(logic [32:0] w);
    int c = 0;
    for (int i = 0; i < 33; i++) c += int'(w[i]);
    return c;
  endfunction

  function automatic logic [4:0] segv(logic [32:0] w);
    int c = cnt(w);
    return (c == 0) ? 5'd0 : (c == 33) ? 5'd31 : 5'(c - 1);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_out(string req);
    chk(req, {5'd0, ovr, code}, {5'd0, m_ovr, m_code});
  endtask

  task automatic do_coarse(logic [32:0] w);
    therm = w; cv = 1'b1;
    @(negedge clk); cv = 1'b0;
    m_tap = segv(w); m_up = segv(w) ^ 5'h10;
    m_oor = (cnt(w) == 0) || (cnt(w) == 33); m_neg = (cnt(w) == 0);
    chk("R4 tap", {11'd0, tap}, {11'd0, m_tap});
    chk_out("R5 hold after coarse");
  endtask

  task automatic do_fine(logic [32:0] w);
    therm = w; fv = 1'b1;
    @(negedge clk); fv = 1'b0;
    m_lo = segv(w);
    chk_out("R5 hold after fine");
  endtask

  task automatic do_xfer(string req);
    xv = 1'b1;
    @(negedge clk); xv = 1'b0;
    m_ovr = m_oor; m_code = m_oor ? {m_neg, 9'd0} : {m_up, m_lo};
    chk_out(req);
  endtask

  task automatic conv(logic [32:0] c, logic [32:0] f, string req);
    do_coarse(c); do_fine(f); do_xfer(req);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    logic [9:0] ref_code;
    seed = int'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R1 reset", {5'd0, ovr, code}, 16'd0);
    chk("R1 reset tap", {11'd0, tap}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    conv(lvl(17), lvl(1), "R2 zero");
    chk("R2 zero literal", {6'd0, code}, 16'h000);
    conv(lvl(16), lvl(33), "R2 minus one lsb");
    chk("R2 minus one literal", {6'd0, code}, 16'h3FF);
    conv(lvl(32), lvl(32), "R2 plus full scale");
    chk("R2 plus fs literal", {6'd0, code}, 16'h1FF);
    conv(lvl(1), lvl(1), "R2 minus full scale");
    chk("R2 minus fs literal", {6'd0, code}, 16'h200);

    conv(lvl(33), lvl(20), "R6 positive over-range");
    chk("R6 pos literal", {5'd0, ovr, code}, 16'h400);
    chk("R4 tap high", {11'd0, tap}, 16'd31);
    conv(lvl(0), lvl(33), "R6 negative over-range");
    chk("R6 neg literal", {5'd0, ovr, code}, 16'h600);
    chk("R4 tap low", {11'd0, tap}, 16'd0);

    conv(lvl(20), lvl(0), "R3 fine empty");
    chk("R3 fine zero literal", {11'd0, code[4:0]}, 16'd0);
    conv(lvl(20), lvl(33), "R3 fine full");
    chk("R3 fine sat literal", {11'd0, code[4:0]}, 16'd31);

    conv(lvl(20), lvl(9), "R7 clean");
    ref_code = code;
    conv((lvl(20) & ~(33'd1 << 18)) | (33'd1 << 20),
         (lvl(9) & ~(33'd1 << 5)) | (33'd1 << 12), "R7 bubble");
    chk("R7 bubble equals clean", {6'd0, code}, {6'd0, ref_code});

    conv(lvl(10), lvl(7), "R8 setup");
    therm = lvl(25); cv = 1'b1; fv = 1'b1;
    @(negedge clk); cv = 1'b0; fv = 1'b0;
    m_tap = 5'd24; m_up = 5'd24 ^ 5'h10; m_oor = 1'b0; m_neg = 1'b0;
    do_xfer("R8 coarse wins");
    chk("R8 lower kept literal", {11'd0, code[4:0]}, 16'd6);

    do_coarse(lvl(5));
    therm = lvl(30); fv = 1'b1; xv = 1'b1;
    @(negedge clk); fv = 1'b0; xv = 1'b0;
    m_ovr = 1'b0; m_code = {m_up, m_lo}; m_lo = 5'd29;
    chk_out("R9 xfer takes old holding");
    do_xfer("R9 later xfer takes new");

    for (int k = 0; k < 300; k++) begin
      logic [32:0] cw, fw;
      int nc, nf;
      nc = $urandom_range(0, 33);
      nf = $urandom_range(0, 33);
      cw = lvl(nc);
      fw = lvl(nf);
      if (nc >= 3 && nc <= 32 && $urandom_range(0, 3) == 0)
        cw = (cw & ~(33'd1 << (nc - 2))) | (33'd1 << nc);
      conv(cw, fw, "R2 R3 R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule